// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

A 32-pin general-purpose I/O port controlled through a small memory-mapped register window with a single-cycle write strobe and a combinational read. Software never writes a pin's level register directly. It writes a mask to a set register to raise pins or to a clear register to lower them. Either write also turns the addressed pins into driven outputs, so no separate direction write exists for output. A pin goes back to high-impedance input through a release register.

Each pad level passes through a two-stage synchroniser and can be read from a level register. The read is only meaningful after the input path has been armed. Arming happens by writing the arming register once, with any data value. Until then the level register reads as zero. The block is placed next to the pads, and its output latch and output-enable vectors drive the pad cells.

Top module: `gpio_sc_port`

## Requirements
- R1: After reset every pin is an input (`pinOe` all 0), every output latch is 0 (`pinOut` all 0), and the input path is unarmed.
- R2: A write to address 0 (set) drives high every pin whose data bit is 1. Pins whose data bit is 0 keep their level.
- R3: A write to address 1 (clear) drives low every pin whose data bit is 1. Pins whose data bit is 0 keep their level.
- R4: A write to address 0 or 1 sets `pinOe` for each pin whose data bit is 1. The direction of the other pins is unchanged.
- R5: A write to address 2 (release) clears `pinOe` for each pin whose data bit is 1 and leaves all output latch levels unchanged.
- R6: While unarmed, a read of address 3 (level) returns 0 whatever the pads carry.
- R7: A write to address 4 (arm) arms the input path whatever data is written, including all zeros. Once armed, it stays armed until reset.
- R8: Once armed, a change on `pinIn` is visible in a level read after the second rising clock edge, and not after the first.
- R9: Once armed, a level read returns the pad level of every pin, whether that pin is currently an input or a driven output.
- R10: Writes to address 3 or to addresses 5 to 7 change neither `pinOut` nor `pinOe`. Reads of any address other than 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Single-cycle write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 32 | Write data mask |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| pinIn | input | 32 | Pad input levels, asynchronous |
| pinOut | output | 32 | Output latch levels to pads |
| pinOe | output | 32 | Output enables to pads (1 = driven) |

## Verification
The assertions assume that `pinIn` comes back from real pads: on a driven pin it follows `pinOut`. They also assume that `busWe` is high for only one cycle per access. The bench builds a pad model that applies `pinOe`/`pinOut` over a randomly changing external pattern. It writes and reads only at falling edges, with one strobe per access. Level reads in the random phase come at least two edges after the last pad change, so the bench expects the settled value. A directed case measures the synchroniser latency edge by edge.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int PORT_W      = 32;
  localparam int ADDR_W      = 3;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_SET = 3'd0,
    REG_CLR = 3'd1,
    REG_REL = 3'd2,
    REG_LVL = 3'd3,
    REG_ARM = 3'd4
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [PORT_W-1:0] setMask;
    logic [PORT_W-1:0] clrMask;
    logic [PORT_W-1:0] relMask;
    logic              armed;
    logic              lvlRead;
  } stb_t;
endpackage

// File: rtl/gpio_sc_ctrl.sv
module gpio_sc_ctrl
  import gpio_sc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWdata,
  output stb_t              stb
);
  logic armedQ;
  logic armHit;

  assign armHit = busWe && (busAddr == REG_ARM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       armedQ <= 1'b0;
    else if (armHit) armedQ <= 1'b1;
  end

  always_comb begin
    stb = '0;
    stb.armed   = armedQ;
    stb.lvlRead = (busAddr == REG_LVL);
    if (busWe) begin
      unique case (busAddr)
        REG_SET: stb.setMask = busWdata;
        REG_CLR: stb.clrMask = busWdata;
        REG_REL: stb.relMask = busWdata;
        default: ;
      endcase
    end
  end

  // R7
  arm_only_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armedQ) |-> $past(busWe && (busAddr == REG_ARM)));
  // R7
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |=> armedQ);
endmodule

// File: rtl/gpio_sc_datapath.sv
module gpio_sc_datapath
  import gpio_sc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stb_t              stb,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe,
  output logic [PORT_W-1:0] lvlData
);
  logic [PORT_W-1:0] syncQ [SYNC_STAGES];

  // Output latches: clear takes priority over set on the same bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinOut <= '0;
    else       pinOut <= (pinOut | stb.setMask) & ~stb.clrMask;
  end

  // Level writes imply drive; release returns to input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinOe <= '0;
    else       pinOe <= (pinOe | stb.setMask | stb.clrMask) & ~stb.relMask;
  end

  // Input synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign lvlData = stb.armed ? syncQ[SYNC_STAGES-1] : '0;

  // Checker state: cycles since reset, saturating at the sync depth
  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmCnt <= '0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
  end

  // R2
  set_drives_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(stb.setMask & ~stb.clrMask)) |=>
      ((pinOut & $past(stb.setMask & ~stb.clrMask)) == $past(stb.setMask & ~stb.clrMask)));
  // R3
  clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.clrMask) |=> ((pinOut & $past(stb.clrMask)) == '0));
  // R4
  write_enables_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(stb.setMask | stb.clrMask)) |=>
      ((pinOe & $past(stb.setMask | stb.clrMask)) == $past(stb.setMask | stb.clrMask)));
  // R5
  release_keeps_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.relMask) |=> (((pinOe & $past(stb.relMask)) == '0) && $stable(pinOut)));
  // R10
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setMask == '0 && stb.clrMask == '0 && stb.relMask == '0) |=>
      ($stable(pinOut) && $stable(pinOe)));
  // R6
  unarmed_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.armed |-> (lvlData == '0));
  // R8: two-stage depth written out to keep $past fixed
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.armed && warmCnt == 2'd2) |-> (lvlData == $past(pinIn, 2)));
endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
  import gpio_sc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe
);
  stb_t              stb;
  logic [PORT_W-1:0] lvlData;

  gpio_sc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .stb(stb)
  );

  gpio_sc_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .lvlData(lvlData)
  );

  assign busRdata = stb.lvlRead ? lvlData : '0;
endmodule

// File: tb/gpio_sc_port_bench.sv
module gpio_sc_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinOut, pinOe;
  logic [31:0] extPins = 32'h0;
  logic [31:0] pinIn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] expOut = '0, expOe = '0;
  bit          expArmed = 0;

  always #4 clk = ~clk;

  // Pad model: driven pins follow the latch, others follow the outside world
  assign pinIn = (pinOe & pinOut) | (~pinOe & extPins);

  gpio_sc_port u_gpio_sc_port (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic logic [31:0] padLevel();
    return (expOe & expOut) | (~expOe & extPins);
  endfunction

  function automatic logic [31:0] expLevelRead();
    return expArmed ? padLevel() : 32'h0;
  endfunction

  function automatic void applyModel(logic [2:0] a, logic [31:0] d);
    case (a)
      3'd0: begin expOut = expOut | d;  expOe = expOe | d; end
      3'd1: begin expOut = expOut & ~d; expOe = expOe | d; end
      3'd2: expOe = expOe & ~d;
      3'd4: expArmed = 1;
      default: ;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic wr(logic [2:0] a, logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
    applyModel(a, d);
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  logic [31:0] r;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    extPins = 32'hA5A5_3C3C;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pinOut", pinOut, 32'h0);
    chk("R1 pinOe", pinOe, 32'h0);
    rd(3'd3, r); chk("R1/R6 unarmed read", r, 32'h0);

    // R2, R4: set drives high and enables
    wr(3'd0, 32'h0000_00F0);
    chk("R2 set level", pinOut, 32'h0000_00F0);
    chk("R4 set enables", pinOe, 32'h0000_00F0);
    repeat (3) @(negedge clk);
    rd(3'd3, r); chk("R6 still unarmed", r, 32'h0);

    // R7: arm with data zero
    wr(3'd4, 32'h0);
    rd(3'd3, r); chk("R7 arm with zero data", r, expLevelRead());

    // R3: clear bits 4,5; direction kept, other bits unaffected
    wr(3'd1, 32'h0000_0030);
    chk("R3 clear level", pinOut, 32'h0000_00C0);
    chk("R4 clear keeps enables", pinOe, 32'h0000_00F0);

    // R5: release keeps latch level
    wr(3'd2, 32'h0000_00F0);
    chk("R5 release oe", pinOe, 32'h0);
    chk("R5 release keeps level", pinOut, 32'h0000_00C0);

    // R10: writes to address 3 and 5 do nothing; other reads give 0
    wr(3'd0, 32'h0000_0001);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    chk("R10 ignored write level", pinOut, 32'h0000_00C1);
    chk("R10 ignored write oe", pinOe, 32'h0000_0001);
    rd(3'd0, r); chk("R10 read addr0", r, 32'h0);
    rd(3'd6, r); chk("R10 read addr6", r, 32'h0);

    // R8: latency through the synchroniser on an input pin
    extPins = 32'h0;
    repeat (3) @(negedge clk);
    rd(3'd3, r); chk("R8 baseline", r, expLevelRead());
    extPins = 32'h8000_0000;
    @(negedge clk);
    rd(3'd3, r); chk("R8 not after one edge", r[31], 1'b0);
    @(negedge clk);
    rd(3'd3, r); chk("R8 visible after two edges", r[31], 1'b1);

    // R9: random mix of writes and pad changes
    for (int i = 0; i < 400; i++) begin
      logic [2:0]  a;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: a = 3'd0;
        3, 4, 5: a = 3'd1;
        6, 7:    a = 3'd2;
        8:       a = 3'd3;
        default: a = 3'($urandom_range(5, 7));
      endcase
      d = $urandom;
      if ($urandom_range(0, 1) == 1) extPins = $urandom;
      wr(a, d);
      chk("R2/R3 random level", pinOut, expOut);
      chk("R4/R5 random oe", pinOe, expOe);
      repeat (2) @(negedge clk);
      rd(3'd3, r); chk("R9 random level read", r, expLevelRead());
    end

    // R7: arming survives a second arm write with nonzero data
    wr(3'd4, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    rd(3'd3, r); chk("R7 still armed", r, padLevel());

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule